// File: doc/BRIEF.md
# Embedded Timing Reference Decoder

This block watches an 8-bit video byte stream whose line and field timing are carried in-band. One byte is taken on every rising clock edge. A timing reference is a run of three bytes (0xFF, 0x00, 0x00) followed by a status byte. The block finds these references and reads the field, vertical-blanking and start/end-of-active-video flags from the status byte. From those flags it drives a blanking output, a vertical-blanking output, a field output and a one-cycle line-start pulse.

The stream is also passed on through a short delay line. Each byte leaves the delay line with a flag that marks it as active picture data. The reference bytes themselves are never marked, because the delay lets the block withdraw the mark from the three preamble bytes once the status byte has confirmed them. A packet header of 0x00, 0xFF, 0xFF is reported with a one-cycle pulse; the bytes that follow it are not parsed. Only the in-band codes set the timing. The protection bits in the status byte are not checked or used.

Top module: `vid_trs_decoder`

## Requirements
- R1: While reset is held, the outputs are `blank`=1, `vblank`=1, `field`=0, `line_start`=0, `anc_start`=0 and `vid_valid`=0.
- R2: A status byte is accepted only when the three bytes before it were 0xFF, 0x00, 0x00 in that order and its bit 7 is 1. Bit 6 is F, bit 5 is V and bit 4 is H. Bits 3:0 have no effect on any output.
- R3: After an accepted status byte with H=0 and V=0 (start of active video), `blank` is 0 from the next cycle. After a status byte with H=1 (end of active video), `blank` is 1 from the next cycle.
- R4: After an accepted status byte with V=1, `vblank` is 1 and `blank` stays 1 for the whole line, whatever H is. After one with V=0, `vblank` is 0.
- R5: `field` takes the value of F from every accepted status byte, one cycle after that byte, and holds it until the next accepted status byte.
- R6: `line_start` is high for exactly one cycle after each accepted status byte with H=1. It stays low after a status byte with H=0.
- R7: A byte sampled on edge k appears on `vid_data` after edge k+3. `vid_valid` is 1 only for bytes that lie strictly between an accepted start-of-active-video code (H=0, V=0) and the 0xFF that opens the next reference.
- R8: A 0xFF that is not followed by 0x00, 0x00 and a byte with bit 7 = 1 changes neither `field`, `vblank`, `blank` nor `line_start`. After such a sequence, the next valid reference is decoded normally.
- R9: `anc_start` is high for one cycle after the last byte of the sequence 0x00, 0xFF, 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; one byte is sampled per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 8 | Incoming byte stream with embedded timing codes |
| vid_data | output | 8 | Incoming byte, delayed by the delay line |
| vid_valid | output | 1 | High when `vid_data` is active picture data |
| blank | output | 1 | High outside active picture |
| vblank | output | 1 | V flag of the most recent accepted status byte |
| field | output | 1 | F flag of the most recent accepted status byte (0 = first field) |
| line_start | output | 1 | One-cycle pulse after each end-of-active-video code |
| anc_start | output | 1 | One-cycle pulse after a packet header 0x00, 0xFF, 0xFF |

## Verification
The assertions assume that active picture bytes never take the reserved values 0x00 or 0xFF. They also assume that no status byte equals 0xFF, so a status byte cannot begin a new preamble. The stimulus uses picture values from 0x21 upward and blanking fill values of 0x10 and 0x80. It sends broken preambles and packet headers only while `blank` is high. Status bytes are built from the F, V and H flags, with bit 7 set and the protection nibble never 0xF with all flags set.

// File: rtl/vid_trs_pkg.sv
package vid_trs_pkg;

    // Bytes in a preamble before the status byte.
    localparam int TRS_PRE_LEN = 3;

    typedef struct packed {
        logic fld;   // field flag
        logic vbl;   // vertical blanking flag
        logic eav;   // 1: end of active video, 0: start
    } trs_flags_t;

    typedef struct packed {
        logic active;
        logic vbl;
        logic fld;
        logic line_start;
        logic anc_start;
    } trs_state_t;

endpackage

// File: rtl/trs_detect.sv
module trs_detect
    import vid_trs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [TRS_PRE_LEN-1:0][DATA_W-1:0] hist,   // [0] is the newest byte
    input  logic [DATA_W-1:0]                  din,
    output logic                               trs_hit,
    output logic                               anc_hit,
    output trs_flags_t                         flags
);

    localparam logic [DATA_W-1:0] ALL_ONES  = '1;
    localparam logic [DATA_W-1:0] ALL_ZEROS = '0;

    logic [TRS_PRE_LEN-1:0] pre_ok;

    // The oldest byte of the window must be all ones; the others must be zero.
    generate
        for (genvar i = 0; i < TRS_PRE_LEN; i++) begin : g_pre
            if (i == TRS_PRE_LEN - 1) begin : g_ones
                assign pre_ok[i] = (hist[i] == ALL_ONES);
            end else begin : g_zero
                assign pre_ok[i] = (hist[i] == ALL_ZEROS);
            end
        end
    endgenerate

    assign trs_hit   = (&pre_ok) && din[DATA_W-1];
    assign anc_hit   = (hist[1] == ALL_ZEROS) && (hist[0] == ALL_ONES) && (din == ALL_ONES);
    assign flags.fld = din[DATA_W-2];
    assign flags.vbl = din[DATA_W-3];
    assign flags.eav = din[DATA_W-4];

endmodule

// File: rtl/trs_delay_line.sv
module trs_delay_line
    import vid_trs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = TRS_PRE_LEN + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [DATA_W-1:0]                  in_data,
    input  logic                               in_tag,
    input  logic                               clr_pre,
    output logic [DATA_W-1:0]                  out_data,
    output logic                               out_tag,
    output logic [TRS_PRE_LEN-1:0][DATA_W-1:0] hist
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              tag;
    } stage_t;

    stage_t [DEPTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0].data = in_data;
        st_d[0].tag  = in_tag;
        for (int i = 1; i < DEPTH; i++) begin
            st_d[i] = st_q[i-1];
            // Bytes just confirmed as a preamble lose their picture mark.
            if (clr_pre && (i <= TRS_PRE_LEN)) begin
                st_d[i].tag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar i = 0; i < TRS_PRE_LEN; i++) begin : g_hist
            assign hist[i] = st_q[i].data;
        end
    endgenerate

    assign out_data = st_q[DEPTH-1].data;
    assign out_tag  = st_q[DEPTH-1].tag;

endmodule

// File: rtl/vid_trs_decoder.sv
module vid_trs_decoder
    import vid_trs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] vid_data,
    output logic              vid_valid,
    output logic              blank,
    output logic              vblank,
    output logic              field,
    output logic              line_start,
    output logic              anc_start
);

    localparam int PIPE_DEPTH = TRS_PRE_LEN + 1;

    logic [TRS_PRE_LEN-1:0][DATA_W-1:0] hist;
    logic       trs_hit;
    logic       anc_hit;
    trs_flags_t flags;
    trs_state_t st_d, st_q;

    trs_detect #(.DATA_W(DATA_W)) detect_i (
        .hist    (hist),
        .din     (din),
        .trs_hit (trs_hit),
        .anc_hit (anc_hit),
        .flags   (flags)
    );

    trs_delay_line #(.DATA_W(DATA_W), .DEPTH(PIPE_DEPTH)) delay_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (din),
        .in_tag   (st_q.active && !trs_hit),
        .clr_pre  (trs_hit),
        .out_data (vid_data),
        .out_tag  (vid_valid),
        .hist     (hist)
    );

    always_comb begin
        st_d            = st_q;
        st_d.line_start = 1'b0;
        st_d.anc_start  = anc_hit;
        if (trs_hit) begin
            st_d.fld        = flags.fld;
            st_d.vbl        = flags.vbl;
            st_d.active     = !flags.eav && !flags.vbl;
            st_d.line_start = flags.eav;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, vbl: 1'b1, fld: 1'b0, line_start: 1'b0, anc_start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign blank      = !st_q.active;
    assign vblank     = st_q.vbl;
    assign field      = st_q.fld;
    assign line_start = st_q.line_start;
    assign anc_start  = st_q.anc_start;

endmodule

// File: rtl/vid_trs_decoder_chk.sv
module vid_trs_decoder_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] vid_data,
    input logic              vid_valid,
    input logic              blank,
    input logic              vblank,
    input logic              field,
    input logic              line_start,
    input logic              anc_start
);

    assert_line_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

    assert_eav_blanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> blank);

    assert_vblank_keeps_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |-> !vblank);

    assert_field_needs_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field) |-> $past(din[DATA_W-1]));

    assert_line_start_from_eav_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> ($past(din[DATA_W-1]) && $past(din[DATA_W-4])));

    assert_anc_after_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        anc_start |-> ($past(din) == {DATA_W{1'b1}}));

    assert_valid_not_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> ((vid_data != {DATA_W{1'b0}}) && (vid_data != {DATA_W{1'b1}})));

endmodule

bind vid_trs_decoder vid_trs_decoder_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .vid_data   (vid_data),
    .vid_valid  (vid_valid),
    .blank      (blank),
    .vblank     (vblank),
    .field      (field),
    .line_start (line_start),
    .anc_start  (anc_start)
);

// File: tb/vid_trs_decoder_tb_top.sv
`timescale 1ns/1ps
module vid_trs_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h10;
    logic [7:0] vid_data;
    logic       vid_valid, blank, vblank, field, line_start, anc_start;

    int n_chk  = 0;
    int n_fail = 0;
    int ngot   = 0;
    logic [7:0] got [0:63];
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vid_trs_decoder #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .vid_data(vid_data), .vid_valid(vid_valid),
        .blank(blank), .vblank(vblank), .field(field), .line_start(line_start), .anc_start(anc_start)
    );

    // Collect marked picture bytes, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && vid_valid && ngot < 64) begin
            got[ngot] = vid_data;
            ngot++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Entered at a falling edge; returns at the next falling edge, outputs updated.
    task automatic send(input logic [7:0] b);
        din = b;
        @(negedge clk);
    endtask

    task automatic send_code(input bit f, input bit v, input bit h, input logic [3:0] prot);
        send(8'hFF); send(8'h00); send(8'h00);
        send({1'b1, f, v, h, prot});
    endtask

    task automatic flush();
        for (int i = 0; i < 4; i++) send(8'h10);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "blank",      blank,      1);
        chk("R1", "vblank",     vblank,     1);
        chk("R1", "field",      field,      0);
        chk("R1", "line_start", line_start, 0);
        chk("R1", "anc_start",  anc_start,  0);
        chk("R1", "vid_valid",  vid_valid,  0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_active_line();
        int base;
        send_code(0, 0, 1, 4'hD);
        chk("R6", "line_start after EAV", line_start, 1);
        chk("R3", "blank after EAV", blank, 1);
        send(8'h80);
        chk("R6", "line_start one cycle", line_start, 0);
        send(8'h10); send(8'h80);
        send_code(0, 0, 0, 4'h0);
        chk("R3", "blank after SAV", blank, 0);
        chk("R4", "vblank after V=0", vblank, 0);
        chk("R6", "no line_start on SAV", line_start, 0);
        base = ngot;
        for (int i = 0; i < 8; i++) send(8'h21 + 8'(i));
        send_code(0, 0, 1, 4'h3);
        chk("R3", "blank after closing EAV", blank, 1);
        chk("R2", "EAV with other protection bits", line_start, 1);
        flush();
        chk("R7", "picture byte count", ngot - base, 8);
        for (int i = 0; i < 8; i++)
            chk("R7", "picture byte value", got[base + i], 8'h21 + 8'(i));
    endtask

    task automatic t_latency();
        // Byte sampled on edge k must show on vid_data after edge k+3.
        send_code(0, 0, 0, 4'h0);
        send(8'h5A);
        send(8'h10); send(8'h10);
        chk("R7", "data two edges later", vid_valid, 0);
        send(8'h10);
        chk("R7", "latency data", vid_data, 8'h5A);
        chk("R7", "latency valid", vid_valid, 1);
        send_code(0, 0, 1, 4'h0);
        flush();
    endtask

    task automatic t_vblank_line();
        int base;
        send_code(0, 1, 1, 4'h6);
        chk("R4", "vblank after V=1 EAV", vblank, 1);
        send(8'h80); send(8'h10);
        send_code(0, 1, 0, 4'hB);
        chk("R4", "blank held on V=1 SAV", blank, 1);
        chk("R4", "vblank held", vblank, 1);
        base = ngot;
        for (int i = 0; i < 4; i++) send(8'h40 + 8'(i));
        chk("R4", "blank through V=1 line", blank, 1);
        send_code(0, 1, 1, 4'h6);
        flush();
        chk("R7", "no picture bytes in V=1 line", ngot - base, 0);
    endtask

    task automatic t_field();
        int base;
        send_code(1, 0, 0, 4'h7);
        chk("R5", "field after F=1", field, 1);
        chk("R3", "blank after F=1 SAV", blank, 0);
        base = ngot;
        send(8'h33); send(8'h34);
        send_code(1, 0, 1, 4'hA);
        chk("R5", "field held at F=1", field, 1);
        send(8'h80);
        chk("R5", "field stable between codes", field, 1);
        send_code(0, 1, 1, 4'h1);
        chk("R5", "field back to 0", field, 0);
        flush();
        chk("R7", "field-2 picture bytes", ngot - base, 2);
    endtask

    task automatic t_broken();
        send_code(0, 1, 1, 4'h0);
        send(8'h10);
        // 0xFF followed by 0x00 and a non-zero byte.
        send(8'hFF); send(8'h00); send(8'h40); send(8'hD0);
        chk("R8", "field after broken preamble", field, 0);
        chk("R8", "line_start after broken preamble", line_start, 0);
        chk("R8", "vblank after broken preamble", vblank, 1);
        // Correct preamble, status with bit 7 cleared.
        send(8'hFF); send(8'h00); send(8'h00); send(8'h50);
        chk("R8", "field after bit7=0 status", field, 0);
        chk("R8", "vblank after bit7=0 status", vblank, 1);
        chk("R8", "line_start after bit7=0 status", line_start, 0);
        // Doubled 0xFF, then a valid code: still decoded.
        send(8'hFF);
        send_code(1, 0, 1, 4'h0);
        chk("R8", "recovery line_start", line_start, 1);
        chk("R8", "recovery field", field, 1);
        chk("R8", "recovery vblank", vblank, 0);
        send(8'h10);
    endtask

    task automatic t_anc();
        send(8'h00); send(8'hFF);
        chk("R9", "no pulse before header end", anc_start, 0);
        send(8'hFF);
        chk("R9", "anc_start pulse", anc_start, 1);
        send(8'h40);
        chk("R9", "anc_start one cycle", anc_start, 0);
        chk("R9", "no line_start on header", line_start, 0);
        flush();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_active_line();
        t_latency();
        t_vblank_line();
        t_field();
        t_broken();
        t_anc();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule